// File: doc/BRIEF.md
# Platform-level interrupt controller

This block collects a parameterised set of external interrupt sources and distributes them to a parameterised set of contexts. A context is one privilege mode of one hardware thread. Every source passes through its own gateway, which turns a raw input into a single pending request. A gateway is set either by a rising edge or by a held level, and the choice is made per source. Each context owns an enable mask and a priority threshold. It sees the best eligible pending source at every cycle and raises its interrupt-request line while such a source exists.

Software uses a small synchronous register bus. It programs source priorities, trigger types, per-context enables and thresholds, and it reads the pending bits. A handler claims a source by reading its context's claim/complete register. The read returns the winning source ID and takes that source out of the pending set. The handler finishes by writing the same ID back to the same register. Between claim and completion the source's gateway forwards no new request. When edge queuing is selected by parameter, edges seen in that window are counted and replayed one per completion. Supervisor-mode bus accesses are refused until machine mode sets a delegation bit.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset every pending bit, priority, trigger-type bit, enable mask, threshold and the delegation bit read as 0, and every `irq_o` bit is 0.
- R2: A context considers only sources whose bit is set in its enable mask. `irq_o[c]` is 1 only while some pending source is enabled for context c.
- R3: Among a context's eligible pending sources, the one with the highest priority wins. On equal priority the lower source ID wins.
- R4: A source is eligible for a context only when its priority is nonzero and at least that context's threshold. A priority equal to the threshold passes. A priority of 0 never raises an interrupt.
- R5: A read of a context's claim register returns the winning source ID and clears that source's pending bit in the same access. When nothing is eligible the read returns 0 and changes nothing. Source ID 0 is reserved.
- R6: After a claim, the claimed source stays non-pending until a completion write of its ID arrives at the claim register of a context that has it enabled. A completion write naming a source that is not enabled for the writing context has no effect. So does a completion of a source that is not claimed.
- R7: Trigger-type register bit s = 1 makes source s level-triggered. A level source still asserted after its completion is pending again one cycle after the completion write.
- R8: Edge-triggered sources become pending on a rising input. With QUEUE_EDGES = 1, rising edges seen between claim and completion are counted, saturating at 2^QCNT_W - 1. Each completion then replays one of them as a new pending request. With QUEUE_EDGES = 0 such edges are dropped.
- R9: A supervisor access (`bus_mach_i` = 0) while the delegation bit is 0 is refused. It returns `rsp_err_o` = 1 and read data 0, and it changes no state. The delegation bit can be written only in machine mode; a supervisor access to it is always refused.
- R10: Every request is answered exactly one cycle later by `rsp_valid_o`, and a write returns data 0. Word address map on a 10-bit bus:
  - priority of source s at 0x000+s;
  - pending bits (bit s = source s) at 0x040;
  - trigger type at 0x041;
  - delegation bit (bit 0) at 0x042;
  - enable mask of context c at 0x100+c (bit s = source s);
  - threshold of context c at 0x200+2c;
  - claim/complete of context c at 0x201+2c.
  
  Unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| src_i | input | N_SRC | Raw interrupt inputs, bit s-1 is source s |
| bus_req_i | input | 1 | Bus access request for this cycle |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_mach_i | input | 1 | 1 = machine-mode access, 0 = supervisor-mode access |
| bus_addr_i | input | 10 | Word address |
| bus_wdata_i | input | 32 | Write data |
| rsp_valid_o | output | 1 | Response valid, one cycle after a request |
| rsp_rdata_o | output | 32 | Read data |
| rsp_err_o | output | 1 | Access refused by privilege check |
| irq_o | output | N_CTX | Interrupt request line of each context |

## Verification
Several properties are checked on every cycle by assertions:
- a claimed gateway never re-arms before completion;
- a claim always clears the pending bit it names;
- a held level source re-arms as soon as it is free;
- each context's winner is pending, enabled and at or above its threshold;
- every request receives its one-cycle response;
- a supervisor never alters the delegation bit and is refused while it is clear.

Other behaviours only appear in the bench's scenarios, which compare claim results and pending bits against values worked out from the requirements:
- the tie-break toward the lower ID;
- the exact replay count of queued edges;
- completions that must be ignored;
- the end-to-end register map.

// File: rtl/pic_pkg.sv
package pic_pkg;
  localparam int BUS_AW = 10;
  localparam int BUS_DW = 32;

  typedef enum logic [2:0] {
    RK_NONE,
    RK_PRIO,
    RK_PEND,
    RK_TRIG,
    RK_DELEG,
    RK_EN,
    RK_THR,
    RK_CLAIM
  } reg_kind_e;
endpackage

// File: rtl/irq_gateway.sv
module irq_gateway #(
  parameter int QUEUE_EDGES = 1,
  parameter int QCNT_W      = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic src_i,
  input  logic level_i,
  input  logic claim_i,
  input  logic complete_i,
  output logic pending_o
);
  localparam logic [QCNT_W-1:0] CNT_MAX = {QCNT_W{1'b1}};

  logic              src_q, pend_q, act_q, rise;
  logic [QCNT_W-1:0] cnt_q;

  assign rise      = src_i & ~src_q;
  assign pending_o = pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_q  <= 1'b0;
      pend_q <= 1'b0;
      act_q  <= 1'b0;
      cnt_q  <= '0;
    end else begin
      src_q <= src_i;
      if (claim_i) begin
        pend_q <= 1'b0;
        act_q  <= 1'b1;
      end else if (complete_i && act_q) begin
        act_q <= 1'b0;
        if (!level_i) begin
          if (cnt_q != '0) begin
            pend_q <= 1'b1;
            if (!rise) cnt_q <= cnt_q - 1'b1;
          end else if (rise) begin
            pend_q <= 1'b1;
          end
        end
      end else if (!act_q && !pend_q) begin
        if (level_i ? src_i : rise) pend_q <= 1'b1;
      end else if (act_q && !level_i && rise && (QUEUE_EDGES != 0) && (cnt_q != CNT_MAX)) begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  // R5: a claim leaves the source non-pending and in service
  p_claim_clears_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    claim_i |=> (!pend_q && act_q));

  // R6: no new request while in service and not completed
  p_held_in_service_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_q && !complete_i) |=> !pend_q);

  // R7: a held level input re-arms a free gateway on the next edge
  p_level_rearm_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (level_i && src_i && !act_q && !pend_q && !claim_i) |=> pend_q);

  // R8: in drop mode the replay counter never moves
  p_drop_mode_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (QUEUE_EDGES == 0) |-> (cnt_q == '0));
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
  parameter int N_SRC  = 10,
  parameter int PRIO_W = 3,
  localparam int IDW   = $clog2(N_SRC + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_SRC:0]    pend_i,
  input  logic [N_SRC:0]    en_i,
  input  logic [PRIO_W-1:0] prio_i [N_SRC+1],
  input  logic [PRIO_W-1:0] thr_i,
  output logic [IDW-1:0]    id_o,
  output logic              irq_o
);
  function automatic logic passes(input logic [PRIO_W-1:0] p, input logic [PRIO_W-1:0] t);
    return (p != '0) && (p >= t);
  endfunction

  logic [IDW-1:0]    best_id;
  logic [PRIO_W-1:0] best_p;

  // scan downward so that an equal priority at a lower ID replaces the holder
  always_comb begin
    best_id = '0;
    best_p  = '0;
    for (int s = N_SRC; s >= 0; s--) begin
      if (pend_i[s] && en_i[s] && passes(prio_i[s], thr_i) && (prio_i[s] >= best_p)) begin
        best_id = IDW'(s);
        best_p  = prio_i[s];
      end
    end
  end

  assign id_o  = best_id;
  assign irq_o = (best_id != '0);

  // R3: the winner is a pending source enabled here
  p_winner_pending_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (pend_i[id_o] && en_i[id_o]));

  // R4: the winner clears the threshold with a nonzero priority
  p_winner_thr_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> ((prio_i[id_o] >= thr_i) && (prio_i[id_o] != '0)));
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import pic_pkg::*;
#(
  parameter int N_SRC       = 10,
  parameter int N_CTX       = 9,
  parameter int PRIO_W      = 3,
  parameter int QUEUE_EDGES = 1,
  parameter int QCNT_W      = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_SRC-1:0]  src_i,
  input  logic              bus_req_i,
  input  logic              bus_we_i,
  input  logic              bus_mach_i,
  input  logic [BUS_AW-1:0] bus_addr_i,
  input  logic [BUS_DW-1:0] bus_wdata_i,
  output logic              rsp_valid_o,
  output logic [BUS_DW-1:0] rsp_rdata_o,
  output logic              rsp_err_o,
  output logic [N_CTX-1:0]  irq_o
);
  localparam int IDW  = $clog2(N_SRC + 1);
  localparam int CTXW = (N_CTX > 1) ? $clog2(N_CTX) : 1;

  // configuration state
  logic [PRIO_W-1:0] prio_q [N_SRC+1];
  logic [N_SRC:0]    en_q   [N_CTX];
  logic [PRIO_W-1:0] thr_q  [N_CTX];
  logic [N_SRC:0]    lvl_q;
  logic              deleg_q;

  // source and context state
  logic [N_SRC:0]    pend_vec;
  logic [IDW-1:0]    win_id [N_CTX];
  logic [N_SRC:1]    claim_vec, cmp_vec;

  // decode
  reg_kind_e         kind;
  logic [7:0]        field;
  logic [CTXW-1:0]   ctx_sel;
  logic [IDW-1:0]    src_sel;
  logic              allowed, acc, wr, rd;
  logic              claim_fire, cmp_fire;
  logic [IDW-1:0]    claim_id, cmp_id;
  logic [BUS_DW-1:0] rd_val;

  logic              rsp_valid_q, rsp_err_q;
  logic [BUS_DW-1:0] rsp_rdata_q;

  assign field = bus_addr_i[7:0];

  always_comb begin
    kind    = RK_NONE;
    ctx_sel = '0;
    src_sel = field[IDW-1:0];
    unique case (bus_addr_i[BUS_AW-1 -: 2])
      2'd0: begin
        if (field[7:6] == 2'b00 && field != 8'd0 && 32'(field) <= N_SRC) kind = RK_PRIO;
        else if (field == 8'h40) kind = RK_PEND;
        else if (field == 8'h41) kind = RK_TRIG;
        else if (field == 8'h42) kind = RK_DELEG;
      end
      2'd1: begin
        ctx_sel = field[CTXW-1:0];
        if (32'(field) < N_CTX) kind = RK_EN;
      end
      2'd2: begin
        ctx_sel = field[CTXW:1];
        if (32'(field[7:1]) < N_CTX) kind = field[0] ? RK_CLAIM : RK_THR;
      end
      default: kind = RK_NONE;
    endcase
  end

  // privilege gate: supervisor needs delegation, and never reaches the delegation bit
  assign allowed = bus_mach_i || (deleg_q && (kind != RK_DELEG));
  assign acc     = bus_req_i && allowed;
  assign wr      = acc && bus_we_i;
  assign rd      = acc && !bus_we_i;

  assign claim_id   = win_id[ctx_sel];
  assign claim_fire = rd && (kind == RK_CLAIM);
  assign cmp_id     = bus_wdata_i[IDW-1:0];
  assign cmp_fire   = wr && (kind == RK_CLAIM) && (bus_wdata_i != '0)
                      && (bus_wdata_i <= BUS_DW'(N_SRC)) && en_q[ctx_sel][cmp_id];

  always_comb begin
    for (int s = 1; s <= N_SRC; s++) begin
      claim_vec[s] = claim_fire && (claim_id == IDW'(s));
      cmp_vec[s]   = cmp_fire && (cmp_id == IDW'(s));
    end
  end

  always_comb begin
    unique case (kind)
      RK_PRIO:  rd_val = BUS_DW'(prio_q[src_sel]);
      RK_PEND:  rd_val = BUS_DW'(pend_vec);
      RK_TRIG:  rd_val = BUS_DW'(lvl_q);
      RK_DELEG: rd_val = BUS_DW'(deleg_q);
      RK_EN:    rd_val = BUS_DW'(en_q[ctx_sel]);
      RK_THR:   rd_val = BUS_DW'(thr_q[ctx_sel]);
      RK_CLAIM: rd_val = BUS_DW'(claim_id);
      default:  rd_val = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s <= N_SRC; s++) prio_q[s] <= '0;
      for (int c = 0; c < N_CTX; c++) begin
        en_q[c]  <= '0;
        thr_q[c] <= '0;
      end
      lvl_q   <= '0;
      deleg_q <= 1'b0;
    end else if (wr) begin
      unique case (kind)
        RK_PRIO:  prio_q[src_sel] <= bus_wdata_i[PRIO_W-1:0];
        RK_TRIG:  lvl_q           <= {bus_wdata_i[N_SRC:1], 1'b0};
        RK_DELEG: deleg_q         <= bus_wdata_i[0];
        RK_EN:    en_q[ctx_sel]   <= {bus_wdata_i[N_SRC:1], 1'b0};
        RK_THR:   thr_q[ctx_sel]  <= bus_wdata_i[PRIO_W-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_q <= 1'b0;
      rsp_err_q   <= 1'b0;
      rsp_rdata_q <= '0;
    end else begin
      rsp_valid_q <= bus_req_i;
      rsp_err_q   <= bus_req_i && !allowed;
      rsp_rdata_q <= rd ? rd_val : '0;
    end
  end

  assign rsp_valid_o = rsp_valid_q;
  assign rsp_err_o   = rsp_err_q;
  assign rsp_rdata_o = rsp_rdata_q;

  assign pend_vec[0] = 1'b0;

  generate
    for (genvar s = 1; s <= N_SRC; s++) begin : g_src
      irq_gateway #(
        .QUEUE_EDGES (QUEUE_EDGES),
        .QCNT_W      (QCNT_W)
      ) u_gw (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .src_i      (src_i[s-1]),
        .level_i    (lvl_q[s]),
        .claim_i    (claim_vec[s]),
        .complete_i (cmp_vec[s]),
        .pending_o  (pend_vec[s])
      );
    end

    for (genvar c = 0; c < N_CTX; c++) begin : g_ctx
      irq_arbiter #(
        .N_SRC  (N_SRC),
        .PRIO_W (PRIO_W)
      ) u_arb (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .pend_i (pend_vec),
        .en_i   (en_q[c]),
        .prio_i (prio_q),
        .thr_i  (thr_q[c]),
        .id_o   (win_id[c]),
        .irq_o  (irq_o[c])
      );

      // R2: a raised line implies an enabled pending source for this context
      p_irq_needs_enable_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_o[c] |-> (|(pend_vec & en_q[c])));
    end
  endgenerate

  // R10: every request is answered on the following cycle
  p_rsp_follows_req_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_i |=> rsp_valid_o);

  // R9: undelegated supervisor access is refused with zero data
  p_sup_refused_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_i && !bus_mach_i && !deleg_q) |=> (rsp_err_o && (rsp_rdata_o == '0)));

  // R9: supervisor mode never changes the delegation bit
  p_deleg_machine_only_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_i && !bus_mach_i) |=> $stable(deleg_q));

  // R5: a claim only names a pending source
  p_claim_names_pending_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    claim_fire |-> ((claim_id == '0) || pend_vec[claim_id]));
endmodule

// File: tb/prio_irq_ctrl_tb.sv
module prio_irq_ctrl_tb;
  localparam int NS = 10;
  localparam int NC = 9;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NS-1:0] src = '0;
  logic          req = 1'b0, we = 1'b0, mach = 1'b0;
  logic [9:0]    addr = '0;
  logic [31:0]   wdata = '0;
  logic          rsp_valid, rsp_err;
  logic [31:0]   rsp_rdata;
  logic [NC-1:0] irq;

  int n_chk = 0;
  int n_err = 0;

  always #2 clk = ~clk;  // 250 MHz

  prio_irq_ctrl #(.N_SRC(NS), .N_CTX(NC)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .src_i(src),
    .bus_req_i(req), .bus_we_i(we), .bus_mach_i(mach),
    .bus_addr_i(addr), .bus_wdata_i(wdata),
    .rsp_valid_o(rsp_valid), .rsp_rdata_o(rsp_rdata), .rsp_err_o(rsp_err),
    .irq_o(irq)
  );

  typedef struct packed {
    logic        m;
    logic        w;
    logic [9:0]  a;
    logic [31:0] d;
    logic [31:0] exp_d;
    logic        exp_e;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 1'b1, 10'h003, 32'd5, 32'd0, 1'b0},
    '{1'b1, 1'b0, 10'h003, 32'd0, 32'd5, 1'b0},
    '{1'b1, 1'b0, 10'h000, 32'd0, 32'd0, 1'b0},
    '{1'b0, 1'b0, 10'h003, 32'd0, 32'd0, 1'b1},
    '{1'b0, 1'b1, 10'h003, 32'd1, 32'd0, 1'b1},
    '{1'b1, 1'b0, 10'h003, 32'd0, 32'd5, 1'b0},
    '{1'b1, 1'b1, 10'h042, 32'd1, 32'd0, 1'b0},
    '{1'b0, 1'b1, 10'h200, 32'd2, 32'd0, 1'b0},
    '{1'b0, 1'b0, 10'h200, 32'd0, 32'd2, 1'b0},
    '{1'b0, 1'b1, 10'h042, 32'd0, 32'd0, 1'b1},
    '{1'b1, 1'b0, 10'h042, 32'd0, 32'd1, 1'b0},
    '{1'b1, 1'b1, 10'h042, 32'd0, 32'd0, 1'b0},
    '{1'b1, 1'b1, 10'h200, 32'd0, 32'd0, 1'b0},
    '{1'b0, 1'b0, 10'h200, 32'd0, 32'd0, 1'b1}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic op(input logic m, input logic w, input logic [9:0] a, input logic [31:0] d,
                    output logic [31:0] rdv, output logic erv);
    @(negedge clk);
    req = 1'b1; mach = m; we = w; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
    if (rsp_valid !== 1'b1) begin
      n_chk++; n_err++;
      $display("FAIL R10 response missing actual=%0b expected=1", rsp_valid);
    end
    rdv = rsp_rdata; erv = rsp_err;
  endtask

  task automatic wr_m(input logic [9:0] a, input logic [31:0] d);
    logic [31:0] r; logic e;
    op(1'b1, 1'b1, a, d, r, e);
  endtask

  task automatic rd_m(input logic [9:0] a, output logic [31:0] r);
    logic e;
    op(1'b1, 1'b0, a, 32'd0, r, e);
  endtask

  function automatic logic [9:0] cl_addr(input int c);
    return 10'(32'h201 + 2 * c);
  endfunction

  task automatic claim(input int c, output logic [31:0] id);
    rd_m(cl_addr(c), id);
  endtask

  task automatic complete(input int c, input int id);
    wr_m(cl_addr(c), 32'(id));
  endtask

  task automatic pulse(input logic [NS-1:0] mask);
    @(negedge clk); src = src | mask;
    @(negedge clk); src = src & ~mask;
  endtask

  function automatic logic [NS-1:0] sbit(input int s);
    return NS'(1) << (s - 1);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL R10 watchdog actual=running expected=finished");
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] v; logic e;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1 reset state
    chk("R1 irq after reset", 32'(irq), 32'd0);
    rd_m(10'h040, v); chk("R1 pending after reset", v, 32'd0);
    rd_m(10'h005, v); chk("R1 priority after reset", v, 32'd0);
    rd_m(10'h202, v); chk("R1 threshold after reset", v, 32'd0);
    rd_m(10'h042, v); chk("R1 delegation after reset", v, 32'd0);
    rd_m(10'h041, v); chk("R1 trigger type after reset", v, 32'd0);

    // R9 R10 vector table
    for (int i = 0; i < NV; i++) begin
      op(VECS[i].m, VECS[i].w, VECS[i].a, VECS[i].d, v, e);
      chk($sformatf("R10 R9 vector %0d data", i), v, VECS[i].exp_d);
      chk($sformatf("R10 R9 vector %0d err", i), 32'(e), 32'(VECS[i].exp_e));
    end

    // R3 tie goes to lower ID; R5 empty claim
    wr_m(10'h002, 32'd3);
    wr_m(10'h004, 32'd3);
    wr_m(10'h100, 32'h14);
    pulse(sbit(2) | sbit(4));
    chk("R2 irq ctx0 raised", 32'(irq[0]), 32'd1);
    chk("R2 irq ctx1 not enabled", 32'(irq[1]), 32'd0);
    claim(0, v); chk("R3 tie lower id", v, 32'd2);
    rd_m(10'h040, v); chk("R5 claim cleared pending", v, 32'h10);
    claim(0, v); chk("R3 second claim", v, 32'd4);
    claim(0, v); chk("R5 empty claim", v, 32'd0);
    complete(0, 2); complete(0, 4);

    // R3 higher priority wins over lower ID
    wr_m(10'h006, 32'd6);
    wr_m(10'h100, 32'h54);
    pulse(sbit(4) | sbit(6));
    claim(0, v); chk("R3 higher priority", v, 32'd6);
    complete(0, 6);
    claim(0, v); chk("R3 remaining", v, 32'd4);
    complete(0, 4);

    // R4 threshold
    wr_m(10'h200, 32'd5);
    pulse(sbit(4));
    chk("R4 below threshold no irq", 32'(irq[0]), 32'd0);
    claim(0, v); chk("R4 below threshold claim", v, 32'd0);
    wr_m(10'h200, 32'd3);
    chk("R4 equal threshold irq", 32'(irq[0]), 32'd1);
    claim(0, v); chk("R4 equal threshold claim", v, 32'd4);
    complete(0, 4);
    wr_m(10'h200, 32'd0);

    // R4 priority 0 never raises
    wr_m(10'h100, 32'hD4);
    pulse(sbit(7));
    rd_m(10'h040, v); chk("R4 prio0 source pending", 32'(v[7]), 32'd1);
    chk("R4 prio0 no irq", 32'(irq[0]), 32'd0);
    claim(0, v); chk("R4 prio0 no claim", v, 32'd0);

    // R6 gateway block and ignored completions; R8 queued replay
    pulse(sbit(4));
    claim(0, v); chk("R8 claim edge source", v, 32'd4);
    pulse(sbit(4)); pulse(sbit(4));
    rd_m(10'h040, v); chk("R6 blocked while in service", 32'(v[4]), 32'd0);
    complete(0, 2);
    rd_m(10'h040, v); chk("R6 other id completion ignored", 32'(v[4]), 32'd0);
    complete(1, 4);
    rd_m(10'h040, v); chk("R6 not-enabled completion ignored", 32'(v[4]), 32'd0);
    complete(0, 4);
    rd_m(10'h040, v); chk("R8 first replay", 32'(v[4]), 32'd1);
    claim(0, v); chk("R8 replay claim", v, 32'd4);
    complete(0, 4);
    rd_m(10'h040, v); chk("R8 second replay", 32'(v[4]), 32'd1);
    claim(0, v); complete(0, 4);
    rd_m(10'h040, v); chk("R8 queue drained", 32'(v[4]), 32'd0);

    // R7 level source
    wr_m(10'h041, 32'h20);
    wr_m(10'h005, 32'd2);
    wr_m(10'h102, 32'h20);
    @(negedge clk) src = src | sbit(5);
    @(negedge clk);
    chk("R7 level irq ctx2", 32'(irq[2]), 32'd1);
    claim(2, v); chk("R7 level claim", v, 32'd5);
    rd_m(10'h040, v); chk("R7 held while claimed", 32'(v[5]), 32'd0);
    complete(2, 5);
    @(negedge clk);
    rd_m(10'h040, v); chk("R7 re-pending after completion", 32'(v[5]), 32'd1);
    src = src & ~sbit(5);
    claim(2, v); complete(2, 5);
    @(negedge clk);
    rd_m(10'h040, v); chk("R7 released level idle", 32'(v[5]), 32'd0);

    // R9 delegation gates supervisor claims
    pulse(sbit(4));
    op(1'b0, 1'b0, cl_addr(0), 32'd0, v, e);
    chk("R9 refused claim err", 32'(e), 32'd1);
    chk("R9 refused claim data", v, 32'd0);
    rd_m(10'h040, v); chk("R9 refused claim no effect", 32'(v[4]), 32'd1);
    wr_m(10'h042, 32'd1);
    op(1'b0, 1'b0, cl_addr(0), 32'd0, v, e);
    chk("R9 delegated claim", v, 32'd4);
    chk("R9 delegated no err", 32'(e), 32'd0);
    op(1'b0, 1'b1, cl_addr(0), 32'd4, v, e);
    wr_m(10'h042, 32'd0);

    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule